// File: doc/BRIEF.md
# Bounds Check Trap Unit

This block decides whether a signed 32-bit operand lies inside a permitted range and produces the condition-flag updates and trap request that go with that decision. It has two modes. In single-bound mode the range runs from zero up to an upper limit. In dual-bound mode the range runs from a lower limit up to an upper limit.

A single valid strobe presents the operand, both limits and the mode bit. One clock later the unit returns the carry, zero and negative flag values. Each flag comes with its own write enable, so the flag register outside the block changes only the flags that the active mode owns. The trap request is returned in the same cycle. When the lower limit is greater than the upper limit, the carry rule treats the range as a band that wraps around: carry is set only for values that lie strictly between the upper and the lower limit.

Top module: `bound_chk_unit`

## Requirements
- R1: `res_vld` is high in the cycle after the cycle in which `req_vld` is sampled high, and low otherwise. After reset it is low.
- R2: In single-bound mode (`req_dual`=0), `neg_we` is 1 and `neg_val` is 1 exactly when the operand is negative (signed).
- R3: In single-bound mode with upper ≥ 0, `cry_val` is 1 when the operand is < 0 or > upper.
- R4: In single-bound mode with upper < 0, `cry_val` is 1 only when the operand is > upper and also < 0.
- R5: In single-bound mode, `trap` is 1 when the operand is < 0 or > upper. This holds even when the upper limit is negative.
- R6: In dual-bound mode (`req_dual`=1), `zro_we` is 1 and `zro_val` is 1 when the operand equals either limit.
- R7: In dual-bound mode with lower ≤ upper, `cry_val` is 1 when the operand is < lower or > upper. With lower > upper, `cry_val` is 1 only when the operand is > upper and < lower.
- R8: In dual-bound mode, `trap` equals `cry_val`.
- R9: `cry_we` is 1 in both modes. `zro_we` is 0 in single-bound mode and `neg_we` is 0 in dual-bound mode. All enables and `trap` are 0 whenever `res_vld` is 0.
- R10: All comparisons are signed two's-complement over the full operand width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Request strobe |
| req_dual | input | 1 | 1 = dual-bound mode, 0 = single-bound mode |
| req_val | input | 32 | Operand under test (signed) |
| req_lo | input | 32 | Lower limit (signed, dual-bound mode only) |
| req_hi | input | 32 | Upper limit (signed) |
| res_vld | output | 1 | Result valid |
| cry_we | output | 1 | Carry write enable |
| cry_val | output | 1 | Carry value |
| zro_we | output | 1 | Zero write enable |
| zro_val | output | 1 | Zero value |
| neg_we | output | 1 | Negative write enable |
| neg_val | output | 1 | Negative value |
| trap | output | 1 | Trap request |

## Verification
Every result is due exactly one clock edge after the request is sampled, because only one register stage lies between the inputs and the outputs. Each test task drives a request on a falling edge and waits for the next rising edge, where the result is captured. It then compares all outputs at the following falling edge. On that same falling edge the strobe is removed, which also lets the task check that the valid and the enables have returned to zero in the idle cycle after the result.

// File: rtl/bound_chk_pkg.sv
package bound_chk_pkg;
  parameter int unsigned DW = 32;

  typedef struct packed {
    logic cry_we;
    logic cry_val;
    logic zro_we;
    logic zro_val;
    logic neg_we;
    logic neg_val;
    logic trap;
  } chk_res_t;
endpackage

// File: rtl/bound_cmp.sv
module bound_cmp #(
  parameter int unsigned DW = 32
) (
  input  logic signed [DW-1:0] a,
  input  logic signed [DW-1:0] b,
  output logic                 lt,
  output logic                 eq
);
  always_comb begin
    lt = (a < b);
    eq = (a == b);
  end
endmodule

// File: rtl/bound_eval.sv
module bound_eval
  import bound_chk_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic          dual,
  input  logic [W-1:0]  val,
  input  logic [W-1:0]  lo,
  input  logic [W-1:0]  hi,
  output chk_res_t      res
);
  logic [W-1:0] lo_eff;
  logic v_lt_lo, v_eq_lo, hi_lt_v, hi_eq_v, hi_lt_lo, hi_eq_lo;
  logic below, above, in_order, cry;

  // lower limit is zero in single-bound mode
  always_comb lo_eff = dual ? lo : '0;

  bound_cmp #(.DW(W)) u_cmp_vlo (.a(val), .b(lo_eff), .lt(v_lt_lo), .eq(v_eq_lo));
  bound_cmp #(.DW(W)) u_cmp_hiv (.a(hi),  .b(val),    .lt(hi_lt_v), .eq(hi_eq_v));
  bound_cmp #(.DW(W)) u_cmp_hlo (.a(hi),  .b(lo_eff), .lt(hi_lt_lo), .eq(hi_eq_lo));

  always_comb begin
    below    = v_lt_lo;
    above    = hi_lt_v;
    in_order = ~hi_lt_lo;
    cry      = in_order ? (below | above) : (below & above);
    res.cry_we  = 1'b1;
    res.cry_val = cry;
    res.zro_we  = dual;
    res.zro_val = dual & (v_eq_lo | hi_eq_v);
    res.neg_we  = ~dual;
    res.neg_val = ~dual & val[W-1];
    res.trap    = dual ? cry : (below | above);
  end
endmodule

// File: rtl/bound_chk_unit.sv
module bound_chk_unit
  import bound_chk_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_vld,
  input  logic         req_dual,
  input  logic [W-1:0] req_val,
  input  logic [W-1:0] req_lo,
  input  logic [W-1:0] req_hi,
  output logic         res_vld,
  output logic         cry_we,
  output logic         cry_val,
  output logic         zro_we,
  output logic         zro_val,
  output logic         neg_we,
  output logic         neg_val,
  output logic         trap
);
  chk_res_t comb_res, res_d, res_q;
  logic vld_d, vld_q;

  bound_eval #(.W(W)) u_eval (
    .dual(req_dual), .val(req_val), .lo(req_lo), .hi(req_hi), .res(comb_res)
  );

  always_comb begin
    vld_d = req_vld;
    res_d = res_q;
    if (req_vld) res_d = comb_res;
    else begin
      res_d.cry_we = 1'b0;
      res_d.zro_we = 1'b0;
      res_d.neg_we = 1'b0;
      res_d.trap   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= vld_d;
      res_q <= res_d;
    end
  end

  always_comb begin
    res_vld = vld_q;
    cry_we  = res_q.cry_we;
    cry_val = res_q.cry_val;
    zro_we  = res_q.zro_we;
    zro_val = res_q.zro_val;
    neg_we  = res_q.neg_we;
    neg_val = res_q.neg_val;
    trap    = res_q.trap;
  end
endmodule

// File: rtl/bound_chk_sva.sv
module bound_chk_sva #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         req_vld,
  input logic         req_dual,
  input logic [W-1:0] req_val,
  input logic [W-1:0] req_hi,
  input logic         res_vld,
  input logic         cry_we,
  input logic         cry_val,
  input logic         zro_we,
  input logic         neg_we,
  input logic         neg_val,
  input logic         trap
);
  assert_res_vld_R1: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld == $past(req_vld));
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !res_vld |-> !(cry_we | zro_we | neg_we | trap));
  assert_we_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> cry_we && $onehot0({zro_we, neg_we}) && (zro_we != neg_we));
  assert_dual_trap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && zro_we) |-> (trap == cry_val));
  assert_neg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld && !req_dual |=> neg_we && (neg_val == $past(req_val[W-1])));
  assert_single_trap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld && !req_dual && !req_val[W-1] && ($signed(req_val) <= $signed(req_hi)) |=> !trap);
endmodule

bind bound_chk_unit bound_chk_sva #(.W(W)) u_sva (
  .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_dual(req_dual),
  .req_val(req_val), .req_hi(req_hi), .res_vld(res_vld), .cry_we(cry_we),
  .cry_val(cry_val), .zro_we(zro_we), .neg_we(neg_we), .neg_val(neg_val),
  .trap(trap)
);

// File: tb/bound_chk_unit_tb.sv
module bound_chk_unit_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic req_vld, req_dual;
  logic [31:0] req_val, req_lo, req_hi;
  logic res_vld, cry_we, cry_val, zro_we, zro_val, neg_we, neg_val, trap;
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  bound_chk_unit u_dut (.*);

  task automatic chk(string rq, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b", rq, what, act, exp);
    end
  endtask

  // single-bound: expected from the requirements
  task automatic run_single(string rq, int v, int hi);
    logic c, t;
    t = (v < 0) || (v > hi);
    c = (hi >= 0) ? t : ((v > hi) && (v < 0));
    @(negedge clk);
    req_vld = 1; req_dual = 0; req_val = v; req_lo = 32'h5A5A_5A5A; req_hi = hi;
    @(negedge clk);
    req_vld = 0;
    chk(rq, "res_vld", res_vld, 1'b1);
    chk("R2", "neg_we", neg_we, 1'b1);
    chk("R2", "neg_val", neg_val, v < 0);
    chk(rq, "cry_val", cry_val, c);
    chk("R5", "trap", trap, t);
    chk("R9", "cry_we", cry_we, 1'b1);
    chk("R9", "zro_we", zro_we, 1'b0);
    @(negedge clk);
    chk("R1", "res_vld idle", res_vld, 1'b0);
    chk("R9", "enables idle", cry_we | zro_we | neg_we | trap, 1'b0);
  endtask

  task automatic run_dual(string rq, int v, int lo, int hi);
    logic c, z;
    c = (lo <= hi) ? ((v < lo) || (v > hi)) : ((v > hi) && (v < lo));
    z = (v == lo) || (v == hi);
    @(negedge clk);
    req_vld = 1; req_dual = 1; req_val = v; req_lo = lo; req_hi = hi;
    @(negedge clk);
    req_vld = 0;
    chk(rq, "res_vld", res_vld, 1'b1);
    chk("R7", "cry_val", cry_val, c);
    chk("R8", "trap", trap, c);
    chk("R6", "zro_we", zro_we, 1'b1);
    chk("R6", "zro_val", zro_val, z);
    chk("R9", "neg_we", neg_we, 1'b0);
    @(negedge clk);
    chk("R1", "res_vld idle", res_vld, 1'b0);
  endtask

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; req_vld = 0; req_dual = 0; req_val = 0; req_lo = 0; req_hi = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1", "reset res_vld", res_vld, 1'b0);
    chk("R9", "reset trap", trap, 1'b0);
    run_single("R3", 5, 10);
    run_single("R3", 10, 10);
    run_single("R3", 11, 10);
    run_single("R3", -1, 10);
    run_single("R3", 0, 0);
    run_single("R4", -3, -5);
    run_single("R4", -7, -5);
    run_single("R4", 4, -5);
    run_single("R10", 32'h8000_0000, 32'h7FFF_FFFF);
    run_dual("R7", 5, 0, 10);
    run_dual("R6", 0, 0, 10);
    run_dual("R6", 10, 0, 10);
    run_dual("R7", -1, 0, 10);
    run_dual("R7", 11, 0, 10);
    run_dual("R7", 3, 10, 0);
    run_dual("R7", 20, 10, 0);
    run_dual("R7", -4, 10, 0);
    run_dual("R10", -2, -5, 3);
    run_dual("R10", 32'h7FFF_FFFF, 32'h8000_0000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule